// File: doc/BRIEF.md
# Sequential Multiply/Divide Unit

This unit holds three data registers of W bits (an operand register X and a pair Y/Z that together hold a 2W-bit value) plus a two-bit operation register. Software-side logic loads the registers through a single write port, chooses an operation, and pulses `start`. The unit then spends one clock per operand bit on the job and signals completion with a one-cycle `done` pulse. All registers are always visible on readback outputs.

Multiplication is unsigned shift-and-add. The multiplicand sits in X and the multiplier in Z. The 2W-bit product ends in the pair, with Y as the high half.

Division is unsigned restoring division. The 2W-bit dividend sits in the pair, with Y as the high half, and the divisor sits in X. Each step shifts the pair left by one. It then subtracts X from Y when X does not exceed the shifted Y, including the bit pushed out of Y, and records the outcome in Z bit 0. At the end, Z holds the quotient and Y the remainder. A zero divisor raises a flag instead of running.

Top module: `muldiv_seq`

## Requirements
- R1: After reset, X, Y, Z and the operation register read zero, and `busy`, `done` and `div_zero` are low.
- R2: A write with `wr_en` high stores `wr_data` into the register picked by `wr_sel`: 00 X, 01 Y, 10 Z, 11 the operation register (from `wr_data[1:0]`). Any write made while `busy` is high is ignored.
- R3: A `start` with operation code 00 (no operation) raises neither `busy` nor `done` and leaves every register unchanged.
- R4: With operation code 01 (multiply), Y is cleared at start. When `done` pulses, {Y,Z} equals the unsigned product of the starting X and Z.
- R5: With operation code 10 (divide) and a dividend high half below X, Z holds the quotient and Y the remainder of {Y,Z} divided by X when `done` pulses. X is never changed by an operation.
- R6: With W = 4, a dividend of 0010 1001 and a divisor of 0111 give Z = 0101 and Y = 0110.
- R7: The divide comparison includes the bit shifted out of the top of Y. With W = 4, a dividend of 1110 1111 and a divisor of 1111 give Z = 1111 and Y = 1110.
- R8: Operation code 11 runs as a multiply.
- R9: A divide started with X = 0 sets `div_zero`, keeps `busy` low, pulses `done` in the next cycle and leaves Y and Z unchanged. Each later accepted start clears `div_zero` unless it is again a divide by zero.
- R10: After an accepted start on a nonzero job, `busy` is high for exactly W cycles beginning in the next cycle. `done` is high for exactly the one cycle after `busy` falls, and `done` and `busy` are never high together.
- R11: A `start` while `busy` is high is ignored: the running job completes with its original result and only one `done` pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, deasserted synchronously |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Target register: 00 X, 01 Y, 10 Z, 11 operation |
| wr_data | input | W | Write data; bits [1:0] carry the operation code |
| start | input | 1 | Start request for the stored operation |
| x_out | output | W | X readback |
| y_out | output | W | Y readback (high half of the pair) |
| z_out | output | W | Z readback (low half of the pair) |
| op_out | output | 2 | Operation register readback |
| busy | output | 1 | Job in progress |
| done | output | 1 | One-cycle completion pulse |
| div_zero | output | 1 | Last accepted divide had a zero divisor |

## Verification
The bench builds the unit with W = 4. That width makes every multiplier/multiplicand pair (256 products) practical, as well as every dividend whose high half is below a nonzero divisor. These sweeps reach every carry out of the multiply add and every case where the divide comparison depends on the bit shifted out of Y. The same width also allows the two fixed divide examples to be checked bit for bit. A scoreboard queue carries the expected pair, X and flag for each job, and a monitor compares them on each `done` pulse. This also exposes a spurious second pulse when `start` is repeated during a run.

// File: rtl/muldiv_pkg.sv
package muldiv_pkg;
  typedef enum logic [1:0] {
    OP_NONE = 2'b00,
    OP_MUL  = 2'b01,
    OP_DIV  = 2'b10,
    OP_BAD  = 2'b11
  } op_e;

  typedef enum logic [1:0] {
    SEL_X   = 2'b00,
    SEL_Y   = 2'b01,
    SEL_Z   = 2'b10,
    SEL_CTL = 2'b11
  } sel_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } state_e;
endpackage

// File: rtl/muldiv_opdec.sv
module muldiv_opdec #(
  parameter bit BAD_AS_MUL = 1'b1
) (
  input  logic [1:0] op_code,
  output logic       is_mul,
  output logic       is_div
);
  import muldiv_pkg::*;

  generate
    if (BAD_AS_MUL) begin : g_bad_mul
      always_comb begin
        is_mul = (op_code == OP_MUL) || (op_code == OP_BAD);
        is_div = (op_code == OP_DIV);
      end
    end else begin : g_bad_div
      always_comb begin
        is_mul = (op_code == OP_MUL);
        is_div = (op_code == OP_DIV) || (op_code == OP_BAD);
      end
    end
  endgenerate
endmodule

// File: rtl/muldiv_step.sv
module muldiv_step #(
  parameter int W = 8
) (
  input  logic         div_mode,
  input  logic [W-1:0] x_val,
  input  logic [W-1:0] y_val,
  input  logic [W-1:0] z_val,
  output logic [W-1:0] y_next,
  output logic [W-1:0] z_next
);
  logic [W:0]   acc_sum;
  logic [W-1:0] y_mul;
  logic [W-1:0] z_mul;
  logic [W:0]   y_wide;
  logic [W-1:0] z_shift;
  logic [W:0]   y_less;
  logic         fits;
  logic [W-1:0] y_div;
  logic [W-1:0] z_div;

  // multiply: conditional add with carry, then shift carry/Y/Z right
  always_comb begin
    acc_sum = z_val[0] ? ({1'b0, y_val} + {1'b0, x_val}) : {1'b0, y_val};
    y_mul   = acc_sum[W:1];
    z_mul   = {acc_sum[0], z_val[W-1:1]};
  end

  // divide: shift pair left, keep the bit leaving Y for the compare
  always_comb begin
    y_wide  = {y_val, z_val[W-1]};
    z_shift = {z_val[W-2:0], 1'b0};
    fits    = (y_wide >= {1'b0, x_val});
    y_less  = y_wide + {1'b1, ~x_val} + {{W{1'b0}}, 1'b1};
    if (fits) begin
      y_div = y_less[W-1:0];
      z_div = z_shift | {{(W-1){1'b0}}, 1'b1};
    end else begin
      y_div = y_wide[W-1:0];
      z_div = z_shift;
    end
  end

  always_comb begin
    y_next = div_mode ? y_div : y_mul;
    z_next = div_mode ? z_div : z_mul;
  end
endmodule

// File: rtl/muldiv_ctrl.sv
module muldiv_ctrl #(
  parameter int W = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic launch,
  input  logic finish_now,
  output logic busy,
  output logic done,
  output logic step_en
);
  import muldiv_pkg::*;

  localparam int CW = (W > 1) ? $clog2(W) : 1;
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  state_e        st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          done_q, done_d;
  logic          last_step;

  assign last_step = (cnt_q == LAST);

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    done_d = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (launch) begin
          st_d  = ST_RUN;
          cnt_d = '0;
        end else if (finish_now) begin
          done_d = 1'b1;
        end
      end
      ST_RUN: begin
        cnt_d = cnt_q + 1'b1;
        if (last_step) begin
          st_d   = ST_IDLE;
          done_d = 1'b1;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      done_q <= done_d;
    end
  end

  assign busy    = (st_q == ST_RUN);
  assign done    = done_q;
  assign step_en = (st_q == ST_RUN);

  // R10: completion pulse never overlaps a running job
  a_r10_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  // R10: the end of a run is always announced in the following cycle
  a_r10_fall_done: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);
  // R11: a run keeps going until its last step, whatever start does
  a_r11_run_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !last_step) |=> busy);
endmodule

// File: rtl/muldiv_seq.sv
module muldiv_seq #(
  parameter int W          = 8,
  parameter bit BAD_AS_MUL = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [1:0]   wr_sel,
  input  logic [W-1:0] wr_data,
  input  logic         start,
  output logic [W-1:0] x_out,
  output logic [W-1:0] y_out,
  output logic [W-1:0] z_out,
  output logic [1:0]   op_out,
  output logic         busy,
  output logic         done,
  output logic         div_zero
);
  import muldiv_pkg::*;

  logic [W-1:0] x_q, x_d, y_q, y_d, z_q, z_d;
  logic [1:0]   op_q, op_d;
  logic         dmode_q, dmode_d;
  logic         dz_q, dz_d;
  logic         is_mul, is_div;
  logic         accept, zero_div, launch, step_en;
  logic [W-1:0] y_step, z_step;

  muldiv_opdec #(.BAD_AS_MUL(BAD_AS_MUL)) u_dec (
    .op_code (op_q),
    .is_mul  (is_mul),
    .is_div  (is_div)
  );

  muldiv_step #(.W(W)) u_step (
    .div_mode (dmode_q),
    .x_val    (x_q),
    .y_val    (y_q),
    .z_val    (z_q),
    .y_next   (y_step),
    .z_next   (z_step)
  );

  assign accept   = start && !busy && (is_mul || is_div);
  assign zero_div = accept && is_div && (x_q == '0);
  assign launch   = accept && !zero_div;

  muldiv_ctrl #(.W(W)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .launch     (launch),
    .finish_now (zero_div),
    .busy       (busy),
    .done       (done),
    .step_en    (step_en)
  );

  always_comb begin
    x_d     = x_q;
    y_d     = y_q;
    z_d     = z_q;
    op_d    = op_q;
    dmode_d = dmode_q;
    dz_d    = dz_q;
    if (wr_en && !busy) begin
      case (wr_sel)
        SEL_X:   x_d  = wr_data;
        SEL_Y:   y_d  = wr_data;
        SEL_Z:   z_d  = wr_data;
        default: op_d = wr_data[1:0];
      endcase
    end
    if (accept) dz_d = zero_div;
    if (launch) begin
      dmode_d = is_div;
      if (is_mul) y_d = '0;
    end
    if (step_en) begin
      y_d = y_step;
      z_d = z_step;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x_q     <= '0;
      y_q     <= '0;
      z_q     <= '0;
      op_q    <= OP_NONE;
      dmode_q <= 1'b0;
      dz_q    <= 1'b0;
    end else begin
      x_q     <= x_d;
      y_q     <= y_d;
      z_q     <= z_d;
      op_q    <= op_d;
      dmode_q <= dmode_d;
      dz_q    <= dz_d;
    end
  end

  assign x_out    = x_q;
  assign y_out    = y_q;
  assign z_out    = z_q;
  assign op_out   = op_q;
  assign div_zero = dz_q;

  // R2 / R5: X cannot move while a job runs
  a_r2_x_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(x_q));
  // R9: a fresh divide-by-zero flag coincides with completion
  a_r9_flag_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dz_q) |-> (done && !busy));
  // R3: the empty opcode never starts a job
  a_r3_none_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && op_q == OP_NONE) |=> (!busy && !done));
  // R8: the illegal code launches a multiply
  a_r8_bad_is_mul: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && op_q == OP_BAD && BAD_AS_MUL) |=> (busy && !dmode_q));
endmodule

// File: tb/muldiv_seq_bench.sv
module muldiv_seq_bench;
  localparam int W = 4;

  typedef struct {
    logic [W-1:0] x;
    logic [W-1:0] y;
    logic [W-1:0] z;
    logic         dz;
    string        req;
  } exp_t;

  logic         clk, rst_n, wr_en, start;
  logic [1:0]   wr_sel;
  logic [W-1:0] wr_data;
  logic [W-1:0] x_out, y_out, z_out;
  logic [1:0]   op_out;
  logic         busy, done, div_zero;

  int   n_chk  = 0;
  int   n_fail = 0;
  exp_t sb_q[$];

  muldiv_seq #(.W(W)) u_muldiv_seq (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .start(start), .x_out(x_out), .y_out(y_out),
    .z_out(z_out), .op_out(op_out), .busy(busy), .done(done),
    .div_zero(div_zero)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string req,
                     input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // monitor: compares each completion against the scoreboard
  always @(negedge clk) begin
    if (rst_n && done) begin
      if (sb_q.size() == 0) begin
        chk(1'b0, "R11 unexpected done", 16'(done), 16'h0);
      end else begin
        exp_t e;
        e = sb_q.pop_front();
        chk(y_out == e.y, e.req, 16'(y_out), 16'(e.y));
        chk(z_out == e.z, e.req, 16'(z_out), 16'(e.z));
        chk(x_out == e.x, e.req, 16'(x_out), 16'(e.x));
        chk(div_zero == e.dz, e.req, 16'(div_zero), 16'(e.dz));
      end
    end
  end

  task automatic wr(input logic [1:0] sel, input logic [W-1:0] d);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic pulse_start();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  // count busy cycles until done, then step past the pulse
  task automatic wait_done(input int exp_busy, input string req);
    int n = 0;
    int guard = 0;
    while (!done && guard < 100) begin
      if (busy) n++;
      guard++;
      @(negedge clk);
    end
    chk(n == exp_busy, req, 16'(n), 16'(exp_busy));
    @(negedge clk);
    chk(!done, req, 16'(done), 16'h0);
  endtask

  task automatic run_op(input logic [1:0] op, input logic [W-1:0] x,
                        input logic [W-1:0] y, input logic [W-1:0] z,
                        input string req);
    exp_t e;
    logic [2*W-1:0] r;
    wr(2'b00, x); wr(2'b01, y); wr(2'b10, z); wr(2'b11, {{(W-2){1'b0}}, op});
    e.x = x; e.req = req; e.dz = 1'b0;
    if (op == 2'b10) begin
      if (x == 0) begin
        e.y = y; e.z = z; e.dz = 1'b1;
      end else begin
        r   = {y, z} / {{W{1'b0}}, x};
        e.z = r[W-1:0];
        r   = {y, z} % {{W{1'b0}}, x};
        e.y = r[W-1:0];
      end
    end else begin
      r   = {{W{1'b0}}, x} * {{W{1'b0}}, z};
      e.y = r[2*W-1:W];
      e.z = r[W-1:0];
    end
    sb_q.push_back(e);
    pulse_start();
    wait_done((op == 2'b10 && x == 0) ? 0 : W, "R10 busy length");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; start = 1'b0; wr_sel = 2'b00; wr_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk({x_out, y_out, z_out} == '0, "R1", 16'({x_out, y_out, z_out}), 16'h0);
    chk({op_out, busy, done, div_zero} == '0, "R1",
        16'({op_out, busy, done, div_zero}), 16'h0);

    // R2 write and readback
    wr(2'b00, 4'h5); wr(2'b01, 4'h9); wr(2'b10, 4'h3); wr(2'b11, 4'h2);
    chk(x_out == 4'h5, "R2", 16'(x_out), 16'h5);
    chk(y_out == 4'h9, "R2", 16'(y_out), 16'h9);
    chk(z_out == 4'h3, "R2", 16'(z_out), 16'h3);
    chk(op_out == 2'b10, "R2", 16'(op_out), 16'h2);

    // R3 empty opcode
    wr(2'b11, 4'h0);
    pulse_start();
    repeat (3) begin
      chk(!busy && !done, "R3", 16'({busy, done}), 16'h0);
      @(negedge clk);
    end
    chk({x_out, y_out, z_out} == 12'h593, "R3", 16'({x_out, y_out, z_out}), 16'h593);

    // R6 and R7 fixed divide cases
    run_op(2'b10, 4'b0111, 4'b0010, 4'b1001, "R6");
    run_op(2'b10, 4'b1111, 4'b1110, 4'b1111, "R7");

    // R8 illegal code behaves as multiply
    run_op(2'b11, 4'd13, 4'h7, 4'd11, "R8");

    // R9 divide by zero, then cleared by next accepted start
    run_op(2'b10, 4'h0, 4'hA, 4'h6, "R9");
    run_op(2'b01, 4'h3, 4'h0, 4'h4, "R9 clear");

    // R11 start and X write during a run are ignored
    begin
      exp_t e;
      wr(2'b00, 4'd9); wr(2'b10, 4'd7); wr(2'b11, 4'h1);
      e.x = 4'd9; e.y = 4'h3; e.z = 4'hF; e.dz = 1'b0; e.req = "R11";
      sb_q.push_back(e);
      pulse_start();
      wr(2'b00, 4'h1);
      pulse_start();
      wait_done(W - 2, "R11 busy after restart attempt");
      repeat (W + 2) @(negedge clk);
      chk(sb_q.size() == 0, "R11", 16'(sb_q.size()), 16'h0);
    end

    // R4 every product
    for (int a = 0; a < 16; a++)
      for (int b = 0; b < 16; b++)
        run_op(2'b01, 4'(a), 4'(a ^ b), 4'(b), "R4");

    // R5 every division whose quotient fits
    for (int d = 1; d < 16; d++)
      for (int h = 0; h < d; h++)
        for (int l = 0; l < 16; l++)
          run_op(2'b10, 4'(d), 4'(h), 4'(l), "R5");

    chk(sb_q.size() == 0, "R10", 16'(sb_q.size()), 16'h0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule